// File: doc/BRIEF.md
# Q31 Pair Round-and-Pack to Q15

This block takes two signed Q31 operands in one cycle and reduces each to a signed Q15 halfword. It rounds each operand to nearest by adding half of a result LSB, then keeps the upper sixteen bits of the sum. Only a positive operand can overflow this addition, because the added constant is positive. Such an operand is detected by a single signed compare against 0x7FFF7FFF, made before the addition, and its halfword is forced to 0x7FFF.

The two halfwords are packed into one 32-bit word. The word is registered and appears one cycle after the operands are accepted. Any saturation raises a sticky overflow bit in a control word output, and that bit stays set until the clear input is pulsed. Two states sequence the output side. ST_EMPTY means no result is being presented. ST_FULL means a result was captured on the last edge. The transition EMPTY->FULL and the transition FULL->FULL happen when in_valid is high. The transition FULL->EMPTY and the transition EMPTY->EMPTY happen when in_valid is low.

Top module: `q31_pair_pack`

## Requirements
- R1: out_valid is high in exactly the cycle after a cycle with in_valid high. out_word changes only on an edge where in_valid is high, and otherwise holds its last value.
- R2: For an operand x with signed value at most 0x7FFF7FFF, its halfword is bits 31..16 of (x + 0x00008000), taken as a 32-bit sum.
- R3: For an operand whose signed value exceeds 0x7FFF7FFF, its halfword is 0x7FFF. Examples: 0x7FFF8000 and 0x7FFFFFFF both saturate, and 0x7FFF7FFF does not (it gives 0x7FFF).
- R4: The halfword from op_first occupies out_word[31:16] and the halfword from op_second occupies out_word[15:0]. For example, 0x7FFFC678 with 0x865432A0 gives 0x7FFF8654, and 0xBEEFFEED with 0x7FFF8000 gives 0xBEF07FFF.
- R5: When an accepted operand saturates in either lane or in both lanes, ctrl_word bit 22 is 1 after the same edge that registers the result.
- R6: Operands with bit 31 set never set ctrl_word bit 22. This includes 0x80000000 (which gives 0x8000) and 0xFFFF8000 (which gives 0x0000).
- R7: ctrl_word bit 22 stays 1 until an edge where clr_sat is high.
- R8: An edge with clr_sat high and no saturating accepted operand leaves bit 22 at 0. When clr_sat and a saturating accepted operand meet on the same edge, bit 22 ends at 1.
- R9: Every ctrl_word bit other than bit 22 reads 0.
- R10: After reset, out_valid, out_word and ctrl_word are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands are accepted on this edge |
| op_first | input | 32 | First Q31 operand, packed into the upper half |
| op_second | input | 32 | Second Q31 operand, packed into the lower half |
| clr_sat | input | 1 | Clears the sticky overflow bit |
| out_valid | output | 1 | The registered result is fresh |
| out_word | output | 32 | Packed pair of Q15 halfwords |
| ctrl_word | output | 32 | Control word; bit 22 is the sticky overflow bit |

## Verification
The bench targets the saturation threshold from both sides. A design whose compare is off by one lets 0x7FFF8000 wrap to 0x8000, or clamps 0x7FFF7FFF although it rounds cleanly. Most negative values such as 0x80000000 and 0xFFFF8000 catch a two-sided compare, which would clamp them or raise the flag wrongly. Lane swaps show up in the two asymmetric packing examples. Clear and saturation on the same edge, and sequences of idle cycles, expose a flag that is not sticky or that gives clear priority over a new event.

// File: rtl/q31_pair_pack_pkg.sv
package q31_pair_pack_pkg;

    typedef enum logic [0:0] {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } pack_state_e;

endpackage

// File: rtl/q31_round_lane.sv
module q31_round_lane #(
    parameter int IN_W  = 32,
    parameter int OUT_W = 16
) (
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] half,
    output logic             sat
);
    localparam int SHIFT = IN_W - OUT_W;
    localparam logic [IN_W-1:0]  MAXPOS = {1'b0, {(IN_W-1){1'b1}}};
    localparam logic [IN_W-1:0]  RND    = {{(IN_W-1){1'b0}}, 1'b1} << (SHIFT-1);
    localparam logic [IN_W-1:0]  LIMIT  = MAXPOS - RND;
    localparam logic [OUT_W-1:0] CLAMP  = {1'b0, {(OUT_W-1){1'b1}}};

    logic [IN_W-1:0] sum;

    always_comb begin
        sat  = $signed(din) > $signed(LIMIT);
        sum  = din + RND;
        half = sat ? CLAMP : sum[IN_W-1:SHIFT];
    end
endmodule

// File: rtl/sat_sticky.sv
module sat_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end
endmodule

// File: rtl/q31_pair_pack.sv
module q31_pair_pack
    import q31_pair_pack_pkg::*;
#(
    parameter int IN_W    = 32,
    parameter int OUT_W   = 16,
    parameter int CTRL_W  = 32,
    parameter int OVF_BIT = 22
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [IN_W-1:0]      op_first,
    input  logic [IN_W-1:0]      op_second,
    input  logic                 clr_sat,
    output logic                 out_valid,
    output logic [2*OUT_W-1:0]   out_word,
    output logic [CTRL_W-1:0]    ctrl_word
);
    localparam int LANES = 2;

    pack_state_e state_q, state_d;
    logic [LANES*OUT_W-1:0] packed_d;
    logic [LANES-1:0]       lane_sat;
    logic                   ovf_flag;

    // lane 1 -> upper half (first operand), lane 0 -> lower half
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [IN_W-1:0]  lane_in;
        logic [OUT_W-1:0] lane_half;
        assign lane_in = (g == LANES-1) ? op_first : op_second;
        q31_round_lane #(.IN_W(IN_W), .OUT_W(OUT_W)) u_lane (
            .din  (lane_in),
            .half (lane_half),
            .sat  (lane_sat[g])
        );
        assign packed_d[g*OUT_W +: OUT_W] = lane_half;
    end

    sat_sticky u_sticky (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (in_valid && (|lane_sat)),
        .clr_i  (clr_sat),
        .flag_o (ovf_flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: state_d = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_d = in_valid ? ST_FULL : ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        out_word <= '0;
        else if (in_valid) out_word <= packed_d;
    end

    always_comb begin
        out_valid = (state_q == ST_FULL);
        ctrl_word = '0;
        ctrl_word[OVF_BIT] = ovf_flag;
    end
endmodule

// File: rtl/q31_pair_pack_chk.sv
module q31_pair_pack_chk #(
    parameter int IN_W    = 32,
    parameter int OUT_W   = 16,
    parameter int CTRL_W  = 32,
    parameter int OVF_BIT = 22
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [IN_W-1:0]    op_first,
    input logic [IN_W-1:0]    op_second,
    input logic               clr_sat,
    input logic               out_valid,
    input logic [2*OUT_W-1:0] out_word,
    input logic [CTRL_W-1:0]  ctrl_word
);
    localparam logic [IN_W-1:0] THRESH =
        {1'b0, {(IN_W-1){1'b1}}} - ({{(IN_W-1){1'b0}}, 1'b1} << (IN_W-OUT_W-1));
    localparam logic [CTRL_W-1:0] OTHER_MASK = ~({{(CTRL_W-1){1'b0}}, 1'b1} << OVF_BIT);

    logic hi_sat, lo_sat;
    assign hi_sat = $signed(op_first)  > $signed(THRESH);
    assign lo_sat = $signed(op_second) > $signed(THRESH);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);  // R1
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);  // R1
    AST_WORD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_word));  // R1
    AST_HI_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && hi_sat) |=> (out_word[2*OUT_W-1:OUT_W] == {1'b0, {(OUT_W-1){1'b1}}}));  // R3
    AST_LO_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lo_sat) |=> (out_word[OUT_W-1:0] == {1'b0, {(OUT_W-1){1'b1}}}));  // R3
    AST_SAT_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (hi_sat || lo_sat)) |=> ctrl_word[OVF_BIT]);  // R5
    AST_NEG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_first[IN_W-1] && op_second[IN_W-1] && !ctrl_word[OVF_BIT])
        |=> !ctrl_word[OVF_BIT]);  // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_word[OVF_BIT] && !clr_sat) |=> ctrl_word[OVF_BIT]);  // R7
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_sat && !(in_valid && (hi_sat || lo_sat))) |=> !ctrl_word[OVF_BIT]);  // R8
    AST_OTHER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_word & OTHER_MASK) == '0);  // R9
endmodule

bind q31_pair_pack q31_pair_pack_chk #(
    .IN_W(IN_W), .OUT_W(OUT_W), .CTRL_W(CTRL_W), .OVF_BIT(OVF_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_first  (op_first),
    .op_second (op_second),
    .clr_sat   (clr_sat),
    .out_valid (out_valid),
    .out_word  (out_word),
    .ctrl_word (ctrl_word)
);

// File: tb/tb_q31_pair_pack.sv
module tb_q31_pair_pack;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_first = '0;
    logic [31:0] op_second = '0;
    logic        clr_sat = 1'b0;
    logic        out_valid;
    logic [31:0] out_word;
    logic [31:0] ctrl_word;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference state
    bit          exp_valid = 1'b0;
    logic [31:0] exp_word = '0;
    bit          exp_flag = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    q31_pair_pack dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_first(op_first), .op_second(op_second), .clr_sat(clr_sat),
        .out_valid(out_valid), .out_word(out_word), .ctrl_word(ctrl_word)
    );

    function automatic bit ref_sat(input logic [31:0] x);
        longint v;
        v = longint'($signed(x));
        return v > 64'sd2147450879;  // 0x7FFF7FFF
    endfunction

    function automatic logic [15:0] ref_half(input logic [31:0] x);
        longint v;
        if (ref_sat(x)) return 16'h7FFF;
        v = longint'($signed(x)) + 64'sd32768;
        return v[31:16];
    endfunction

    task automatic compare(input string tag);
        logic [31:0] exp_ctrl;
        exp_ctrl = 32'(exp_flag) << 22;
        n_vec++;
        if (out_valid !== exp_valid) begin
            n_bad++;
            $display("FAIL R1 %s: out_valid actual %0b expected %0b", tag, out_valid, exp_valid);
        end
        if (out_word !== exp_word) begin
            n_bad++;
            $display("FAIL %s: out_word actual %h expected %h", tag, out_word, exp_word);
        end
        if (ctrl_word !== exp_ctrl) begin
            n_bad++;
            $display("FAIL %s: ctrl_word actual %h expected %h", tag, ctrl_word, exp_ctrl);
        end
    endtask

    task automatic step(input bit v, input logic [31:0] a, input logic [31:0] b,
                        input bit clr, input string tag);
        in_valid  = v;
        op_first  = a;
        op_second = b;
        clr_sat   = clr;
        exp_valid = v;
        if (v) exp_word = {ref_half(a), ref_half(b)};
        if (v && (ref_sat(a) || ref_sat(b))) exp_flag = 1'b1;
        else if (clr) exp_flag = 1'b0;
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] lfsr;
        lfsr = 32'hACE1_2468;
        repeat (3) @(negedge clk);
        compare("R10 reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R10 after release");

        step(1, 32'h7FFFC678, 32'h865432A0, 0, "R4 R3 example one");
        step(0, 32'h0, 32'h0, 1, "R8 clear");
        step(1, 32'hBEEFFEED, 32'h7FFF8000, 0, "R4 R3 example two");
        step(0, 32'h0, 32'h0, 0, "R7 sticky idle");
        step(0, 32'h0, 32'h0, 0, "R1 R7 hold");
        step(1, 32'h0, 32'h0, 0, "R7 sticky on plain input");
        step(0, 32'h0, 32'h0, 1, "R8 clear again");
        step(1, 32'h7FFF7FFF, 32'h7FFF8000, 0, "R2 R3 threshold");
        step(0, 32'h0, 32'h0, 1, "R8 clear");
        step(1, 32'h80000000, 32'hFFFF8000, 0, "R6 negative extremes");
        step(1, 32'hFFFF7FFF, 32'h00008000, 0, "R2 rounding halves");
        step(1, 32'h7FFFFFFF, 32'h7FFFFFFF, 0, "R5 both lanes saturate");
        step(1, 32'h12345678, 32'h7FFFFFFF, 1, "R8 clear with saturation");
        step(1, 32'h00010000, 32'hFFFEFFFF, 1, "R8 clear with plain input");
        step(1, 32'hFFFFFFFF, 32'h80007FFF, 0, "R6 negatives no flag");
        step(0, 32'hDEADBEEF, 32'h7FFFFFFF, 0, "R1 ignored when idle");

        for (int i = 0; i < 300; i++) begin
            logic [31:0] a, b;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = lfsr;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            b = lfsr;
            if (i % 7 == 3) a = 32'h7FFF8000 + 32'(i);
            if (i % 11 == 5) b = 32'h7FFF7FFF - 32'(i);
            step(lfsr[5] | lfsr[9], a, b, (i % 13 == 0), "R2 R3 R4 R5 sweep");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule